// File: doc/BRIEF.md
# Interleaved ADC Channel Sweep Sequencer

This block runs a multi-channel analog-to-digital converter in a continuous sweep. A group of one to four low-numbered channels, always starting at channel 0, is converted over and over. After every full pass through that group, the block converts exactly one channel from outside the group. That outside channel moves up by one on each pass and wraps back to the first channel above the group. The analog front end and the comparator sit outside the block. Each conversion is modelled as a request pulse, a fixed wait and a result word that the front end holds on `conv_data`.

Software sets `start_flag` to launch a sweep and clears it to stop. It can instead arm the sweep and let a rising edge on `ext_trig` launch it. The block divides the system clock into a conversion-clock enable and times each conversion in conversion-clock cycles. The count depends on resolution and on sample-and-hold. The block drops sample-and-hold when the divided clock would be too slow for it. Every finished conversion lands in the result register of the channel that was converted. The block never raises a completion interrupt in this mode.

Top module: `adc_sweep_seq`

## Requirements
- R1: When `start_flag` goes to 1 with `trig_ext_sel`=0, the first conversion starts on channel 0, and `conv_active` is 1 while a sweep runs.
- R2: With `trig_ext_sel`=1, a set `start_flag` only arms the block: no conversion starts and `conv_active` stays 0 until a rising edge on `ext_trig`, and the sweep then starts on channel 0.
- R3: The group size is `grp_sel`+1 (0: channel 0; 1: channels 0–1; 2: channels 0–2; 3: channels 0–3). Conversion order is the group in rising order, then one channel above the group. That extra channel advances by one on each pass, and after channel 7 it wraps to channel `grp_sel`+1.
- R4: Each finished conversion writes the result register of the converted channel, which is bits [ch*10+9 : ch*10] of `res_flat`. In the same cycle `res_wr` pulses for one cycle with that channel on `res_wr_ch`. At 10-bit resolution (`res10_sel`=1) the stored value is `conv_data`. At 8-bit resolution it is `conv_data[7:0]` with bits 9:8 zero.
- R5: One conversion lasts N conversion-clock cycles: N=33 (10-bit) or 28 (8-bit) with sample-and-hold active, and N=59 (10-bit) or 49 (8-bit) without it. The conversion clock is the system clock divided by 1, 2 or 4 for `div_sel` = 0, 1, or 2/3. Consecutive `res_wr` pulses, and a `conv_start` pulse and its result, are exactly N×divisor system cycles apart.
- R6: Sample-and-hold is used only if `sh_en`=1 and SYS_CLK_HZ/divisor ≥ MIN_SH_HZ. Otherwise the non-sample-and-hold cycle counts apply.
- R7: Clearing `start_flag` abandons any conversion in progress. No result is written, `conv_active` is 0 on the next cycle and no `res_wr` follows. The next sweep starts again at channel 0 with the extra-channel pointer back at channel `grp_sel`+1.
- R8: `conv_start` pulses for one cycle at the start of every conversion, with the channel already on `ch_sel`. `ch_sel` does not change while that conversion runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_flag | input | 1 | Run request; clearing it stops the sweep |
| trig_ext_sel | input | 1 | 1: wait for an `ext_trig` rising edge before the first conversion |
| ext_trig | input | 1 | External start trigger |
| res10_sel | input | 1 | 1: 10-bit, 0: 8-bit resolution |
| grp_sel | input | 2 | Selected group size minus one |
| sh_en | input | 1 | Sample-and-hold request |
| div_sel | input | 2 | Conversion clock divide select |
| conv_data | input | 10 | Result word from the converter core |
| conv_active | output | 1 | A sweep is running |
| conv_start | output | 1 | One-cycle pulse at the start of each conversion |
| ch_sel | output | 3 | Channel being converted |
| res_wr | output | 1 | Result write pulse |
| res_wr_ch | output | 3 | Channel written by `res_wr` |
| res_flat | output | 80 | All eight result registers, channel i at bits [i*10+9 : i*10] |

## Verification
The bench predicts every conversion's channel, stored value and spacing. It targets the wrap of the rotating extra channel back to the first unselected channel, which a design with a wrong wrap limit would send to channel 0 or into the group. It runs the divide-by-4 setting with the clock parameter set so that sample-and-hold must be dropped; a design that ignored the floor would finish each conversion in 33 or 28 conversion cycles instead of 59 or 49. It also stops a sweep while the extra channel is being converted and then restarts it. A design that wrote the abandoned result, or that kept its extra-channel pointer, would change channel 3's register or convert channel 3 where channel 1 is expected. Finally, the external-trigger arm state is held without an edge, to catch a design that starts on the level of `start_flag` alone.

// File: rtl/adc_sweep_pkg.sv
// adc_sweep_pkg: shared types and helpers for the sweep sequencer.
// Assumes a group select of at most four channels and a 2-bit divide select.
package adc_sweep_pkg;

    localparam int GRP_W = 2;
    localparam int DIV_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_CONV = 2'd2
    } seq_state_e;

    // Settings captured when a sweep launches.
    typedef struct packed {
        logic [GRP_W-1:0] grp;
        logic             res10;
        logic             sh;
        logic [DIV_W-1:0] div;
    } sweep_cfg_t;

    // Divide ratio for a divide select code: 0->1, 1->2, others->4.
    function automatic int unsigned div_ratio(input logic [DIV_W-1:0] sel);
        case (sel)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 4;
        endcase
    endfunction

endpackage

// File: rtl/adc_clk_en.sv
// adc_clk_en: produces the conversion-clock enable as a one-cycle pulse in
// the system clock domain. The divider is held at zero while not running, so
// the first pulse of a run arrives exactly `ratio` cycles after run rises.
// Assumes the divide select is stable while run is high.
module adc_clk_en
    import adc_sweep_pkg::*;
#(
    parameter int MAX_DIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);

    localparam int CW = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [CW-1:0] dcnt_q;
    logic [CW-1:0] ratio_m1;

    // Terminal count for the selected divide ratio.
    always_comb ratio_m1 = CW'(div_ratio(div_sel) - 1);

    // Divider counter: cleared when idle, wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dcnt_q <= '0;
        end else if (dcnt_q == ratio_m1) begin
            dcnt_q <= '0;
        end else begin
            dcnt_q <= dcnt_q + 1'b1;
        end
    end

    // Enable pulse on the terminal count of a running divider.
    always_comb tick = run && (dcnt_q == ratio_m1);

endmodule

// File: rtl/adc_chan_seq.sv
// adc_chan_seq: walks the channel order of the interleaved sweep. It covers
// the group 0..grp_sel in rising order, then one channel above the group,
// then the group again. The extra channel advances per pass and wraps to
// grp_sel+1 after the highest channel. Assumes grp_sel+1 < NUM_CH.
module adc_chan_seq
    import adc_sweep_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      adv,
    input  logic [GRP_W-1:0]          grp_sel,
    output logic [$clog2(NUM_CH)-1:0] ch
);

    localparam int CHW = $clog2(NUM_CH);
    localparam logic [CHW-1:0] TOP_CH = CHW'(NUM_CH - 1);

    logic [CHW-1:0] cur_q;
    logic [CHW-1:0] xptr_q;
    logic           in_extra_q;
    logic [CHW-1:0] grp_last;
    logic [CHW-1:0] first_extra;

    // Last group channel and first channel outside the group.
    always_comb begin
        grp_last    = CHW'(grp_sel);
        first_extra = grp_last + 1'b1;
    end

    // Channel order state: current channel, extra pointer, extra-slot flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= '0;
            xptr_q     <= CHW'(1);
            in_extra_q <= 1'b0;
        end else if (clear) begin
            cur_q      <= '0;
            xptr_q     <= first_extra;
            in_extra_q <= 1'b0;
        end else if (adv) begin
            if (in_extra_q) begin
                cur_q      <= '0;
                in_extra_q <= 1'b0;
                xptr_q     <= (xptr_q == TOP_CH) ? first_extra : xptr_q + 1'b1;
            end else if (cur_q == grp_last) begin
                cur_q      <= xptr_q;
                in_extra_q <= 1'b1;
            end else begin
                cur_q <= cur_q + 1'b1;
            end
        end
    end

    assign ch = cur_q;

endmodule

// File: rtl/adc_result_bank.sv
// adc_result_bank: one result register per channel, written by a single
// write port and exposed as a flat vector (channel i at [i*RES_W +: RES_W]).
module adc_result_bank #(
    parameter int NUM_CH = 8,
    parameter int RES_W  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_CH)-1:0] wr_ch,
    input  logic [RES_W-1:0]          wr_data,
    output logic [NUM_CH*RES_W-1:0]   res_flat
);

    localparam int CHW = $clog2(NUM_CH);

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_slot
        logic [RES_W-1:0] slot_q;

        // Store the result when this channel is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (wr_en && (wr_ch == CHW'(gi))) begin
                slot_q <= wr_data;
            end
        end

        assign res_flat[gi*RES_W +: RES_W] = slot_q;
    end

endmodule

// File: rtl/adc_sweep_seq.sv
// adc_sweep_seq: top of the interleaved sweep sequencer. It launches a sweep
// on the start flag (or on an external edge when armed) and captures the
// settings at launch. It times each conversion on the conversion-clock
// enable, stores each result in its channel register and abandons the
// running conversion when the flag drops. SYS_CLK_HZ describes clk; it
// decides whether sample-and-hold is allowed at each divide ratio.
module adc_sweep_seq
    import adc_sweep_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int RES_W      = 10,
    parameter int LO_RES_W   = 8,
    parameter int SYS_CLK_HZ = 50_000_000,
    parameter int MIN_SH_HZ  = 1_000_000,
    parameter int N_SH_LO    = 28,
    parameter int N_SH_HI    = 33,
    parameter int N_NS_LO    = 49,
    parameter int N_NS_HI    = 59
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_flag,
    input  logic                      trig_ext_sel,
    input  logic                      ext_trig,
    input  logic                      res10_sel,
    input  logic [1:0]                grp_sel,
    input  logic                      sh_en,
    input  logic [1:0]                div_sel,
    input  logic [RES_W-1:0]          conv_data,
    output logic                      conv_active,
    output logic                      conv_start,
    output logic [$clog2(NUM_CH)-1:0] ch_sel,
    output logic                      res_wr,
    output logic [$clog2(NUM_CH)-1:0] res_wr_ch,
    output logic [NUM_CH*RES_W-1:0]   res_flat
);

    localparam int CHW   = $clog2(NUM_CH);
    localparam int N_MAX = (N_NS_HI > N_NS_LO) ? N_NS_HI : N_NS_LO;
    localparam int CNT_W = $clog2(N_MAX + 1);
    localparam bit SH_OK_D1 = (SYS_CLK_HZ     >= MIN_SH_HZ);
    localparam bit SH_OK_D2 = (SYS_CLK_HZ / 2 >= MIN_SH_HZ);
    localparam bit SH_OK_D4 = (SYS_CLK_HZ / 4 >= MIN_SH_HZ);

    seq_state_e       state_q, state_d;
    sweep_cfg_t       cfg_q;
    logic             launch;
    logic             trig_q;
    logic             trig_rise;
    logic             running;
    logic             tick;
    logic             done;
    logic             sh_eff;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_m1;
    logic [GRP_W-1:0] grp_now;
    logic [CHW-1:0]   cur_ch;
    logic [RES_W-1:0] wr_data;
    logic             conv_start_q;
    logic             res_wr_q;
    logic [CHW-1:0]   res_wr_ch_q;

    assign running   = (state_q == ST_CONV);
    assign trig_rise = ext_trig && !trig_q;

    // Next state: launch, arm for an external edge, or stop on flag clear.
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start_flag) begin
                    if (trig_ext_sel) begin
                        state_d = ST_ARM;
                    end else begin
                        state_d = ST_CONV;
                        launch  = 1'b1;
                    end
                end
            end
            ST_ARM: begin
                if (!start_flag) begin
                    state_d = ST_IDLE;
                end else if (trig_rise) begin
                    state_d = ST_CONV;
                    launch  = 1'b1;
                end
            end
            ST_CONV: begin
                if (!start_flag) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, trigger history and settings captured at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            trig_q  <= 1'b0;
            cfg_q   <= '0;
        end else begin
            state_q <= state_d;
            trig_q  <= ext_trig;
            if (launch) begin
                cfg_q <= '{grp: grp_sel, res10: res10_sel, sh: sh_en, div: div_sel};
            end
        end
    end

    // Conversion length: sample-and-hold only where the divided clock allows.
    always_comb begin
        case (cfg_q.div)
            2'd0:    sh_eff = cfg_q.sh && SH_OK_D1;
            2'd1:    sh_eff = cfg_q.sh && SH_OK_D2;
            default: sh_eff = cfg_q.sh && SH_OK_D4;
        endcase
        case ({cfg_q.res10, sh_eff})
            2'b11:   len_m1 = CNT_W'(N_SH_HI - 1);
            2'b01:   len_m1 = CNT_W'(N_SH_LO - 1);
            2'b10:   len_m1 = CNT_W'(N_NS_HI - 1);
            default: len_m1 = CNT_W'(N_NS_LO - 1);
        endcase
    end

    adc_clk_en #(
        .MAX_DIV (4)
    ) u_clk_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .div_sel (cfg_q.div),
        .tick    (tick)
    );

    // Conversion ends on the last enable of the count, unless stopping.
    assign done = running && start_flag && tick && (cnt_q == len_m1);

    // Conversion-cycle counter, advanced only on the conversion-clock enable.
    always_ff @(posedge clk) begin
        if (!rst_n || !running) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == len_m1) ? '0 : cnt_q + 1'b1;
        end
    end

    assign grp_now = running ? cfg_q.grp : grp_sel;

    adc_chan_seq #(
        .NUM_CH  (NUM_CH)
    ) u_chan_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!running),
        .adv     (done),
        .grp_sel (grp_now),
        .ch      (cur_ch)
    );

    // Result word: full width at 10 bits, low bits zero-extended at 8 bits.
    always_comb begin
        if (cfg_q.res10) begin
            wr_data = conv_data;
        end else begin
            wr_data = {{(RES_W-LO_RES_W){1'b0}}, conv_data[LO_RES_W-1:0]};
        end
    end

    adc_result_bank #(
        .NUM_CH   (NUM_CH),
        .RES_W    (RES_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (done),
        .wr_ch    (cur_ch),
        .wr_data  (wr_data),
        .res_flat (res_flat)
    );

    // Output strobes: conversion start and result write with its channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start_q <= 1'b0;
            res_wr_q     <= 1'b0;
            res_wr_ch_q  <= '0;
        end else begin
            conv_start_q <= launch || done;
            res_wr_q     <= done;
            if (done) begin
                res_wr_ch_q <= cur_ch;
            end
        end
    end

    assign conv_active = running;
    assign conv_start  = conv_start_q;
    assign ch_sel      = cur_ch;
    assign res_wr      = res_wr_q;
    assign res_wr_ch   = res_wr_ch_q;

endmodule

// File: rtl/adc_sweep_chk.sv
// adc_sweep_chk: protocol properties of the sweep sequencer, observed at its
// ports and bound to every instance of the top module.
module adc_sweep_chk #(
    parameter int NUM_CH = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_flag,
    input logic                      trig_ext_sel,
    input logic                      ext_trig,
    input logic                      conv_active,
    input logic                      conv_start,
    input logic [$clog2(NUM_CH)-1:0] ch_sel,
    input logic                      res_wr,
    input logic [$clog2(NUM_CH)-1:0] res_wr_ch
);

    // R1: a sweep always begins on channel 0.
    p_first_ch0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_active) |-> (ch_sel == '0));

    // R2: while armed without an edge, no sweep may begin.
    p_arm_waits_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!conv_active && trig_ext_sel && !ext_trig) |=> !conv_active);

    // R4: the written channel is the one that was being converted.
    p_wr_channel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        res_wr |-> (res_wr_ch == $past(ch_sel)));

    // R7: dropping the flag stops the sweep on the next cycle.
    p_stop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_active && !start_flag) |=> !conv_active);

    // R7: no result is written after the flag is low.
    p_no_late_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !start_flag |=> !res_wr);

    // R8: the channel holds for the whole conversion.
    p_ch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_active && !conv_start) |-> $stable(ch_sel));

    // R8: a new conversion starts together with each result write.
    p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_wr && conv_active) |-> conv_start);

endmodule

bind adc_sweep_seq adc_sweep_chk #(.NUM_CH(NUM_CH)) u_sweep_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_flag   (start_flag),
    .trig_ext_sel (trig_ext_sel),
    .ext_trig     (ext_trig),
    .conv_active  (conv_active),
    .conv_start   (conv_start),
    .ch_sel       (ch_sel),
    .res_wr       (res_wr),
    .res_wr_ch    (res_wr_ch)
);

// File: tb/adc_sweep_seq_tb.sv
// Scoreboard bench: the driver task predicts each conversion (channel, stored
// value, spacing) into a queue and the monitor compares on every res_wr.
// SYS_CLK_HZ is set to 3 MHz so that divide-by-4 drops below the 1 MHz floor.
module adc_sweep_seq_tb;

    localparam int NUM_CH = 8;
    localparam int RES_W  = 10;
    localparam int SYS_HZ = 3_000_000;
    localparam int MIN_HZ = 1_000_000;

    typedef struct {
        int    ch;
        int    data;
        int    gap;
        string gap_req;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start_flag = 1'b0;
    logic                    trig_ext_sel = 1'b0;
    logic                    ext_trig = 1'b0;
    logic                    res10_sel = 1'b0;
    logic [1:0]              grp_sel = 2'd0;
    logic                    sh_en = 1'b0;
    logic [1:0]              div_sel = 2'd0;
    logic [RES_W-1:0]        fe_data = '0;
    logic                    conv_active;
    logic                    conv_start;
    logic [2:0]              ch_sel;
    logic                    res_wr;
    logic [2:0]              res_wr_ch;
    logic [NUM_CH*RES_W-1:0] res_flat;

    exp_t q[$];
    int   exp_bank[NUM_CH];
    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    int   start_cyc = 0;
    int   fe_idx = 0;
    int   salt = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    adc_sweep_seq #(
        .NUM_CH     (NUM_CH),
        .RES_W      (RES_W),
        .SYS_CLK_HZ (SYS_HZ),
        .MIN_SH_HZ  (MIN_HZ)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_flag   (start_flag),
        .trig_ext_sel (trig_ext_sel),
        .ext_trig     (ext_trig),
        .res10_sel    (res10_sel),
        .grp_sel      (grp_sel),
        .sh_en        (sh_en),
        .div_sel      (div_sel),
        .conv_data    (fe_data),
        .conv_active  (conv_active),
        .conv_start   (conv_start),
        .ch_sel       (ch_sel),
        .res_wr       (res_wr),
        .res_wr_ch    (res_wr_ch),
        .res_flat     (res_flat)
    );

    function automatic int model_data(int ch, int idx, int s);
        return (ch * 131 + idx * 29 + s * 7 + 3) % 1024;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Front-end model: latches a word for the requested channel at each start.
    always @(posedge clk) begin
        if (!conv_active) begin
            fe_idx <= 0;
        end else if (conv_start) begin
            fe_data <= RES_W'(model_data(int'(ch_sel), fe_idx, salt));
            fe_idx  <= fe_idx + 1;
        end
    end

    // Monitor: compare every write against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && res_wr) begin
            if (q.size() == 0) begin
                check(1'b0, "R7", "unexpected result write on channel", int'(res_wr_ch), -1);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(int'(res_wr_ch) == e.ch, "R3", "converted channel", int'(res_wr_ch), e.ch);
                check(int'(res_flat[e.ch*RES_W +: RES_W]) == e.data, "R4",
                      "stored result", int'(res_flat[e.ch*RES_W +: RES_W]), e.data);
                check(cyc - start_cyc == e.gap, e.gap_req, "conversion length in cycles",
                      cyc - start_cyc, e.gap);
                exp_bank[e.ch] = e.data;
            end
        end
        if (rst_n && conv_start) begin
            check(conv_active == 1'b1, "R8", "start pulse inside a sweep", int'(conv_active), 1);
            start_cyc = cyc;
        end
    end

    // Driver: predict one sweep, run it until all writes are seen, then stop.
    task automatic run_sweep(int grp, bit r10, bit sh, int dsel, bit ext,
                             int count, int s, int linger);
        int ratio;
        int n;
        bit sh_ok;
        int g;
        int x;
        int k;
        ratio = (dsel == 0) ? 1 : (dsel == 1) ? 2 : 4;
        sh_ok = sh && (SYS_HZ / ratio >= MIN_HZ);
        n = sh_ok ? (r10 ? 33 : 28) : (r10 ? 59 : 49);
        g = grp + 1;
        x = g;
        k = 0;
        while (k < count) begin
            for (int c = 0; c <= g && k < count; c++) begin
                exp_t e;
                e.ch = (c < g) ? c : x;
                e.data = model_data(e.ch, k, s);
                if (!r10) e.data = e.data % 256;
                e.gap = n * ratio;
                e.gap_req = (sh && !sh_ok) ? "R6" : "R5";
                q.push_back(e);
                k++;
            end
            x = (x == NUM_CH - 1) ? g : x + 1;
        end
        @(negedge clk);
        salt = s;
        grp_sel = 2'(grp);
        res10_sel = r10;
        sh_en = sh;
        div_sel = 2'(dsel);
        trig_ext_sel = ext;
        start_flag = 1'b1;
        if (ext) begin
            repeat (40) @(negedge clk);
            check(conv_active == 1'b0, "R2", "armed sweep idle without edge", int'(conv_active), 0);
            check(q.size() == count, "R2", "writes while armed", count - q.size(), 0);
            ext_trig = 1'b1;
            @(negedge clk);
            ext_trig = 1'b0;
            @(negedge clk);
            check(conv_active == 1'b1, "R2", "sweep running after edge", int'(conv_active), 1);
        end else begin
            @(negedge clk);
            @(negedge clk);
            check(conv_active == 1'b1, "R1", "sweep running after start", int'(conv_active), 1);
            check(int'(ch_sel) == 0, "R1", "first channel", int'(ch_sel), 0);
        end
        while (q.size() != 0) @(negedge clk);
        repeat (linger) @(negedge clk);
        start_flag = 1'b0;
        trig_ext_sel = 1'b0;
        @(negedge clk);
        check(conv_active == 1'b0, "R7", "idle after flag clear", int'(conv_active), 0);
        repeat (4) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R1", "watchdog expired", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NUM_CH; i++) exp_bank[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1/R4: reset state.
        check(conv_active == 1'b0, "R1", "reset conv_active", int'(conv_active), 0);
        check(int'(ch_sel) == 0, "R1", "reset ch_sel", int'(ch_sel), 0);
        check(res_wr == 1'b0, "R4", "reset res_wr", int'(res_wr), 0);
        check(res_flat == '0, "R4", "reset results zero", int'(res_flat != '0), 0);

        // R3/R5: single channel group, full extra-channel wrap, 10-bit S&H, /1.
        run_sweep(0, 1'b1, 1'b1, 0, 1'b0, 16, 1, 0);
        // R3/R4/R5: two-channel group, 8-bit masking, no S&H, /2.
        run_sweep(1, 1'b0, 1'b0, 1, 1'b0, 14, 2, 0);
        // R3/R6: four-channel group at /4, S&H requested but forced off.
        run_sweep(3, 1'b0, 1'b1, 2, 1'b0, 22, 3, 0);
        // R3/R5: three-channel group, 10-bit no S&H, /1.
        run_sweep(2, 1'b1, 1'b0, 0, 1'b0, 15, 4, 0);
        // R6: divide code 3 also divides by 4, S&H forced off at 10-bit.
        run_sweep(0, 1'b1, 1'b1, 3, 1'b0, 4, 5, 0);
        // R5/R6: /2 keeps S&H at 1.5 MHz, 10-bit.
        run_sweep(1, 1'b1, 1'b1, 1, 1'b0, 5, 6, 0);
        // R2: external trigger launch.
        run_sweep(1, 1'b1, 1'b1, 1, 1'b1, 6, 7, 0);

        // R7: stop in the middle of the channel-3 extra conversion (0,1,0,2,0 then 3).
        run_sweep(0, 1'b1, 1'b1, 0, 1'b0, 5, 8, 15);
        repeat (80) @(negedge clk);
        check(int'(res_flat[3*RES_W +: RES_W]) == exp_bank[3], "R7",
              "abandoned channel 3 register unchanged",
              int'(res_flat[3*RES_W +: RES_W]), exp_bank[3]);
        // R7/R3: restart resets the extra pointer, so channel 1 follows channel 0.
        run_sweep(0, 1'b1, 1'b1, 0, 1'b0, 3, 9, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule